// File: doc/BRIEF.md
# Programmable Pseudorandom Pattern Generator

This block produces a maximal-length style pseudorandom test stream from a linear feedback shift register whose length and feedback taps are both loaded by software. The register length n can be anything from 1 to 32, and a 32-bit tap mask picks which register bits feed the exclusive-OR feedback. The stream leaves the block one, four or eight bits at a time on an 8-bit output word. The generator advances only on clock edges where the transmit enable is high, so a gapped clock can be modelled by pulsing that enable.

Software reaches the block through a plain write port with four word addresses: the tap mask, the length, a control word (output width and inversion), and an error-insert command. An armed error flips exactly one bit of the next word that is sent. An error-arming FSM has two states: `ERR_IDLE` (nothing pending) and `ERR_ARMED` (one flip pending). The transition `ERR_IDLE -> ERR_ARMED` happens on a valid insert command. The transition `ERR_ARMED -> ERR_IDLE` happens on an enabled cycle that carries no new command. A command that arrives while the FSM is in `ERR_ARMED` keeps it there.

Top module: `prbs_gen`

## Requirements
- R1: After reset the output word is 0x00, the shift register holds all ones, the tap mask is zero, the length is 32, the output is serial, inversion is off and no error is armed.
- R2: On each enabled step the generated bit is register bit n-1. The register then shifts one place towards its MSB, and bit 0 takes the XOR of all register bits that are selected by both the tap mask and the length.
- R3: Address 1 sets the length: n = wr_data[4:0] + 1. Higher data bits at that address have no effect. Address 0 loads the 32-bit tap mask.
- R4: Address 2 bits [1:0] select the output width: 0 is serial on tx_data[0], 1 is nibble on tx_data[3:0], 2 is byte on tx_data[7:0], and 3 behaves as serial. Unused output bits read 0. Within a word, the earliest generated bit sits on the most significant bit of the active lane.
- R5: Each enabled cycle consumes 1, 4 or 8 generator steps for serial, nibble or byte width. Successive words continue the stream with no bits skipped or repeated.
- R6: While tx_en is low the register does not advance and tx_data holds its value.
- R7: Address 2 bit 2 inverts every bit of the active lane. Unused bits stay 0.
- R8: A write to address 3 with wr_data[0]=1 arms one error. On the next enabled cycle after that write, the earliest bit of the word (the lane MSB) is flipped, and the error is then disarmed. The generator sequence itself is not disturbed. A write to address 3 with wr_data[0]=0 has no effect.
- R9: If the register bits within the length are all zero after an enabled cycle, the register is loaded with all ones within the length, so the generator cannot lock up.
- R10: A register write in the same cycle as an enabled step takes effect from the following step. An error command that coincides with the enabled cycle that consumes an earlier error re-arms the block, so that the next enabled word is flipped too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register word address |
| wr_data | input | 32 | Register write data |
| tx_en | input | 1 | Transmit clock enable; advances the generator |
| tx_data | output | 8 | Registered output word |

## Verification
The error-insert command and the enabled step that consumes an armed error can fall in the same cycle. Configuration writes and enabled steps can also coincide. The bench provokes both by asserting wr_en and tx_en together: it sends an insert command on an enabled cycle, and then a second command exactly on the cycle that spends the first. A behavioural model, which applies the step before the write, predicts the word on every clock. The expectation is that the first word is clean and that the two following words are each flipped once. A mode change written on an enabled cycle is likewise expected to shape only the next word.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [1:0] {
        MODE_SER  = 2'd0,
        MODE_NIB  = 2'd1,
        MODE_BYTE = 2'd2,
        MODE_RSV  = 2'd3
    } mode_e;

    typedef enum logic {
        ERR_IDLE  = 1'b0,
        ERR_ARMED = 1'b1
    } err_state_e;

    localparam logic [ADDR_W-1:0] REG_TAPS = 2'd0;
    localparam logic [ADDR_W-1:0] REG_LEN  = 2'd1;
    localparam logic [ADDR_W-1:0] REG_CTRL = 2'd2;
    localparam logic [ADDR_W-1:0] REG_ERR  = 2'd3;

    localparam int CTRL_INV_BIT = 2;

endpackage

// File: rtl/prbs_regs.sv
module prbs_regs
    import prbs_pkg::*;
#(
    parameter int W  = 32,
    parameter int LW = $clog2(W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    output logic [W-1:0]      taps_q,
    output logic [LW-1:0]     len_m1_q,
    output mode_e             mode_q,
    output logic              inv_q,
    output logic              err_req
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taps_q   <= '0;
            len_m1_q <= LW'(W - 1);
            mode_q   <= MODE_SER;
            inv_q    <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_addr)
                REG_TAPS: taps_q   <= wr_data;
                REG_LEN:  len_m1_q <= wr_data[LW-1:0];
                REG_CTRL: begin
                    mode_q <= mode_e'(wr_data[1:0]);
                    inv_q  <= wr_data[CTRL_INV_BIT];
                end
                default: ;
            endcase
        end
    end

    assign err_req = wr_en && (wr_addr == REG_ERR) && wr_data[0];

endmodule

// File: rtl/prbs_err_fsm.sv
module prbs_err_fsm
    import prbs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic req,
    output logic armed,
    output logic flip
);

    err_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ERR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ERR_IDLE:  if (req)            state_d = ERR_ARMED;
            ERR_ARMED: if (tx_en && !req)  state_d = ERR_IDLE;
            default:                       state_d = ERR_IDLE;
        endcase
    end

    always_comb begin
        armed = 1'b0;
        flip  = 1'b0;
        unique case (state_q)
            ERR_IDLE:  ;
            ERR_ARMED: begin
                armed = 1'b1;
                flip  = tx_en;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/prbs_lfsr_core.sv
module prbs_lfsr_core
    import prbs_pkg::*;
#(
    parameter int W         = 32,
    parameter int MAX_STEPS = 8,
    parameter int NIB_STEPS = 4,
    parameter int LW        = $clog2(W)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tx_en,
    input  logic [W-1:0]         taps,
    input  logic [LW-1:0]        len_m1,
    input  mode_e                mode,
    output logic [W-1:0]         state_q,
    output logic [W-1:0]         len_mask,
    output logic [MAX_STEPS-1:0] bits
);

    logic [W-1:0] chain [0:MAX_STEPS];
    logic [W-1:0] picked;
    logic [W-1:0] state_d;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            len_mask[i] = (i <= int'(len_m1));
        end
    end

    assign chain[0] = state_q;

    for (genvar g = 0; g < MAX_STEPS; g++) begin : g_step
        logic fb;
        assign fb          = ^(chain[g] & taps & len_mask);
        assign bits[g]     = chain[g][len_m1];
        assign chain[g+1]  = ({chain[g][W-2:0], fb}) & len_mask;
    end

    always_comb begin
        unique case (mode)
            MODE_NIB:  picked = chain[NIB_STEPS];
            MODE_BYTE: picked = chain[MAX_STEPS];
            default:   picked = chain[1];
        endcase
        state_d = (picked == '0) ? len_mask : picked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     state_q <= '1;
        else if (tx_en) state_q <= state_d;
    end

endmodule

// File: rtl/prbs_gen.sv
module prbs_gen
    import prbs_pkg::*;
#(
    parameter int W     = 32,
    parameter int OUT_W = 8,
    parameter int NIB_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic              tx_en,
    output logic [OUT_W-1:0]  tx_data
);

    localparam int LW = $clog2(W);

    logic [W-1:0]     taps_q;
    logic [LW-1:0]    len_m1_q;
    mode_e            mode_q;
    logic             inv_q;
    logic             err_req;
    logic             err_armed;
    logic             err_flip;
    logic [W-1:0]     lfsr_q;
    logic [W-1:0]     len_mask;
    logic [OUT_W-1:0] bits;
    logic [OUT_W-1:0] word_d;

    prbs_regs #(.W(W), .LW(LW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .taps_q   (taps_q),
        .len_m1_q (len_m1_q),
        .mode_q   (mode_q),
        .inv_q    (inv_q),
        .err_req  (err_req)
    );

    prbs_err_fsm u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .tx_en (tx_en),
        .req   (err_req),
        .armed (err_armed),
        .flip  (err_flip)
    );

    prbs_lfsr_core #(.W(W), .MAX_STEPS(OUT_W), .NIB_STEPS(NIB_W), .LW(LW)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en),
        .taps     (taps_q),
        .len_m1   (len_m1_q),
        .mode     (mode_q),
        .state_q  (lfsr_q),
        .len_mask (len_mask),
        .bits     (bits)
    );

    always_comb begin
        word_d = '0;
        unique case (mode_q)
            MODE_NIB: begin
                for (int i = 0; i < NIB_W; i++) begin
                    word_d[NIB_W-1-i] = bits[i] ^ inv_q;
                end
                word_d[NIB_W-1] = word_d[NIB_W-1] ^ err_flip;
            end
            MODE_BYTE: begin
                for (int i = 0; i < OUT_W; i++) begin
                    word_d[OUT_W-1-i] = bits[i] ^ inv_q;
                end
                word_d[OUT_W-1] = word_d[OUT_W-1] ^ err_flip;
            end
            default: word_d[0] = bits[0] ^ inv_q ^ err_flip;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     tx_data <= '0;
        else if (tx_en) tx_data <= word_d;
    end

endmodule

// File: rtl/prbs_gen_chk.sv
module prbs_gen_chk
    import prbs_pkg::*;
#(
    parameter int W     = 32,
    parameter int OUT_W = 8,
    parameter int NIB_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic              tx_en,
    input  logic [OUT_W-1:0]  tx_data,
    input  logic [W-1:0]      state_q,
    input  logic [W-1:0]      len_mask,
    input  mode_e             mode,
    input  logic              armed
);

    logic err_cmd;
    assign err_cmd = wr_en && (wr_addr == REG_ERR) && wr_data[0];

    p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> ($stable(tx_data) && $stable(state_q)));

    p_no_lockup_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !wr_en) |=> ((state_q & len_mask) != '0));

    p_serial_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && (mode == MODE_SER || mode == MODE_RSV)) |=> (tx_data[OUT_W-1:1] == '0));

    p_nibble_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && mode == MODE_NIB) |=> (tx_data[OUT_W-1:NIB_W] == '0));

    p_err_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_cmd |=> armed);

    p_err_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && tx_en && !err_cmd) |=> !armed);

    p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !tx_en) |=> armed);

endmodule

bind prbs_gen prbs_gen_chk #(.W(W), .OUT_W(OUT_W), .NIB_W(NIB_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .tx_en    (tx_en),
    .tx_data  (tx_data),
    .state_q  (lfsr_q),
    .len_mask (len_mask),
    .mode     (mode_q),
    .armed    (err_armed)
);

// File: tb/prbs_gen_tb.sv
`timescale 1ns/1ps
module prbs_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [31:0] wr_data;
    logic        tx_en;
    logic [7:0]  tx_data;

    always #10 clk = ~clk;

    prbs_gen u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .tx_en   (tx_en),
        .tx_data (tx_data)
    );

    int    checks = 0;
    int    errors = 0;
    bit    finished = 0;
    string tag = "R1";

    logic [31:0] m_s;
    logic [31:0] m_taps;
    int          m_n;
    logic [1:0]  m_mode;
    bit          m_inv;
    bit          m_err;
    logic [7:0]  m_out;

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic void model_edge(bit en, bit we, logic [1:0] a, logic [31:0] d);
        logic [31:0] mask;
        logic [7:0]  b;
        logic [7:0]  w;
        int          k;
        mask = (m_n == 32) ? 32'hFFFF_FFFF : ((32'h1 << m_n) - 32'h1);
        if (en) begin
            k = (m_mode == 2'd1) ? 4 : (m_mode == 2'd2) ? 8 : 1;
            b = '0;
            for (int i = 0; i < k; i++) begin
                b[i] = m_s[m_n-1];
                m_s  = ((m_s << 1) | {31'b0, ^(m_s & m_taps & mask)}) & mask;
            end
            if (m_s == 32'h0) m_s = mask;
            w = '0;
            for (int i = 0; i < k; i++) w[k-1-i] = b[i] ^ m_inv;
            if (m_err) w[k-1] = ~w[k-1];
            m_out = w;
            m_err = 1'b0;
        end
        if (we) begin
            case (a)
                2'd0: m_taps = d;
                2'd1: m_n = int'(d[4:0]) + 1;
                2'd2: begin m_mode = d[1:0]; m_inv = d[2]; end
                default: if (d[0]) m_err = 1'b1;
            endcase
        end
    endfunction

    task automatic cyc(bit en, bit we = 1'b0, logic [1:0] a = 2'd0, logic [31:0] d = 32'd0);
        tx_en   = en;
        wr_en   = we;
        wr_addr = a;
        wr_data = d;
        model_edge(en, we, a, d);
        @(posedge clk);
        @(negedge clk);
        check(tag, tx_data, m_out);
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        cyc(1'b0, 1'b1, a, d);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cyc(1'b1);
    endtask

    initial begin
        #4_000_000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int ones;
        logic [7:0] held;
        rst_n = 1'b0; tx_en = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        m_s = 32'hFFFF_FFFF; m_taps = '0; m_n = 32; m_mode = 2'd0;
        m_inv = 1'b0; m_err = 1'b0; m_out = 8'h00;
        repeat (3) @(negedge clk);
        check("R1", tx_data, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: first serial bit from an all-ones register is 1
        tag = "R1";
        cyc(1'b1);
        check("R1", tx_data, 8'h01);

        // R9: no taps, all-ones seed shifts to zero then reloads
        tag = "R9";
        run(40);
        wr(2'd1, 32'd3);
        run(12);

        // R2: x^3+x^2+1, period 7 holds four ones
        tag = "R2";
        wr(2'd0, 32'h0000_0006);
        wr(2'd1, 32'd2);
        run(3);
        ones = 0;
        for (int i = 0; i < 7; i++) begin
            cyc(1'b1);
            ones += int'(tx_data[0]);
        end
        check("R2", 8'(ones), 8'd4);
        run(7);

        // R3: length 7 written with junk upper bits
        tag = "R3";
        wr(2'd1, 32'hFFFF_FFE6);
        wr(2'd0, 32'h0000_0060);
        run(20);

        // R4: reserved width code acts as serial
        tag = "R4";
        wr(2'd2, 32'd3);
        run(10);

        // R5: nibble and byte streams
        tag = "R5";
        wr(2'd2, 32'd1);
        wr(2'd1, 32'd14);
        wr(2'd0, 32'h0000_6000);
        run(20);
        wr(2'd2, 32'd2);
        wr(2'd1, 32'd22);
        wr(2'd0, 32'h0042_0000);
        run(20);
        wr(2'd1, 32'd31);
        wr(2'd0, 32'h8020_0003);
        run(20);

        // R6: gapped enable, output must hold while idle
        tag = "R6";
        for (int i = 0; i < 60; i++) begin
            bit e;
            e = 1'($urandom_range(1, 0));
            held = tx_data;
            cyc(e);
            if (!e) check("R6", tx_data, held);
        end

        // R7: inversion on each width
        tag = "R7";
        wr(2'd2, 32'h0000_0006);
        run(10);
        wr(2'd2, 32'h0000_0005);
        run(10);
        wr(2'd2, 32'h0000_0004);
        run(10);

        // R8: single flip on next enabled word, ignored command
        tag = "R8";
        wr(2'd2, 32'd2);
        wr(2'd3, 32'd1);
        cyc(1'b0);
        cyc(1'b0);
        run(4);
        wr(2'd3, 32'd0);
        run(4);
        wr(2'd2, 32'd1);
        wr(2'd3, 32'd1);
        run(3);
        wr(2'd2, 32'd0);
        wr(2'd3, 32'hFFFF_FFFF);
        run(3);

        // R10: writes coinciding with enabled steps
        tag = "R10";
        cyc(1'b1, 1'b1, 2'd2, 32'd2);
        run(3);
        cyc(1'b1, 1'b1, 2'd3, 32'd1);
        cyc(1'b1, 1'b1, 2'd3, 32'd1);
        run(4);
        cyc(1'b1, 1'b1, 2'd1, 32'd0);
        wr(2'd0, 32'h0000_0001);
        run(5);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule